// File: doc/BRIEF.md
# Serial Command Decoder for a Banked Potentiometer Register Set

This block is the serial command front end of a single-wiper digital potentiometer. A host talks to it over a four-wire serial link in mode 0 (data sampled on the rising clock edge, changed on the falling edge, most significant bit first). Each transaction is framed by an active-low select. The serial inputs are brought into the block's own clock domain through synchronisers, and the block detects serial clock edges there. The block holds sixteen 8-bit data registers and an 8-bit wiper register. The wiper register value is driven out as the tap setting.

Every frame opens with an identification byte. The byte must carry the device-type code 0101 in its upper nibble, zeros in bits 3:2, and a copy of the two strapped address pins in bits 1:0. If the byte does not match, the rest of the frame is dropped. An instruction byte follows. For the read and write commands, one data byte follows the instruction. The block can read or write the wiper, read or write any data register, and copy a value between a data register and the wiper. The copy commands act only when bank 0 is named. A select that rises early aborts the frame without side effects.

Top module: `spi_pot_cmd`

## Requirements
- R1: After reset the wiper output and all sixteen data registers are 0, the serial-out enable is low and the idle flag is high.
- R2: A frame proceeds only if its first byte has bits 7:4 = 4'b0101, bits 3:2 = 2'b00 and bits 1:0 equal to the address pins. Any other value causes the rest of the frame to be ignored: no register changes and the serial-out enable stays low.
- R3: The instruction byte carries the opcode in bits 7:4, the register-in-bank select in bits 3:2 and the bank number in bits 1:0. The data register index is bank*4 + select.
- R4: Opcode 4'b1001 returns the wiper value on the serial output during the next byte, MSB first. Each bit changes only on a falling serial clock edge and is held across the rising edge where the host samples it.
- R5: Opcode 4'b1010 loads the next full byte into the wiper register, and the new value appears on the wiper output.
- R6: Opcode 4'b1011 returns the addressed data register on the serial output during the next byte, for any bank.
- R7: Opcode 4'b1100 loads the next full byte into the addressed data register, for any bank.
- R8: Opcode 4'b1101 copies data register (bank 0, select) into the wiper. If the bank is 1 to 3, the wiper does not change.
- R9: Opcode 4'b1110 copies the wiper into data register (bank 0, select). If the bank is 1 to 3, no data register changes.
- R10: Any other opcode changes no register, and the data byte that follows it is ignored.
- R11: A rise of the select line before a command completes discards the partial command. The next falling edge of select starts a fresh frame at the identification byte.
- R12: The serial-out enable is high only while read data is being shifted out. The idle flag is high exactly when no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select |
| addr_pins | input | 2 | Strapped device address |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for serial out (low = high impedance) |
| wiper | output | 8 | Wiper tap setting |
| ready | output | 1 | High when no frame is in progress |

## Verification
Every cycle, the assertions check several rules. The output enable is high only in the data phase, and never while the idle flag is set. Both register write strobes never fire together, and any write happens on a completed serial bit. A wiper-write strobe issued while the instruction is decoded names bank 0. The block returns to idle after a select rise, and the wiper changes only inside a frame. The bench scenarios cover the rest: matching the identification byte against the pins, the bank-to-index mapping, the bit order and hold timing of read data, rejection of copies that name banks 1 to 3, unknown opcodes, and the effect of an aborted frame on the registers. The bench shows these by reading registers back and by watching the wiper output.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;
  localparam int BYTE_W        = 8;
  localparam int CNT_W         = $clog2(BYTE_W);
  localparam int NUM_BANKS     = 4;
  localparam int REGS_PER_BANK = 4;
  localparam int BANK_W        = $clog2(NUM_BANKS);
  localparam int RSEL_W        = $clog2(REGS_PER_BANK);
  localparam int NUM_REGS      = NUM_BANKS * REGS_PER_BANK;
  localparam int IDX_W         = BANK_W + RSEL_W;

  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_RD_DR    = 4'b1011;
  localparam logic [3:0] OP_WR_DR    = 4'b1100;
  localparam logic [3:0] OP_DR2W     = 4'b1101;
  localparam logic [3:0] OP_W2DR     = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_INSTR, ST_DATA, ST_SKIP
  } frame_st_e;
endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_pot_regs.sv
module spi_pot_regs
  import spi_pot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_dr,
  input  logic              we_wiper,
  input  logic [IDX_W-1:0]  dr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] dr_rdata,
  output logic [BYTE_W-1:0] wiper
);
  logic [BYTE_W-1:0] mem [NUM_REGS];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[g] <= '0;
        else if (we_dr && (dr_idx == IDX_W'(g))) mem[g] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wiper <= '0;
    else if (we_wiper) wiper <= wr_data;
  end

  assign dr_rdata = mem[dr_idx];

  // R9
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_dr && we_wiper));
endmodule

// File: rtl/spi_pot_ctrl.sv
module spi_pot_ctrl
  import spi_pot_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              si_s,
  input  logic [1:0]        addr_pins,
  input  logic [BYTE_W-1:0] dr_rdata,
  input  logic [BYTE_W-1:0] wiper,
  output logic [IDX_W-1:0]  dr_idx,
  output logic              we_dr,
  output logic              we_wiper,
  output logic [BYTE_W-1:0] wr_data,
  output logic              so,
  output logic              so_oe,
  output logic              ready
);
  frame_st_e         state, state_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [BYTE_W-2:0] rx_sh, rx_sh_n;
  logic [3:0]        op_q, op_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              rd_q, rd_n;
  logic [BYTE_W-1:0] tx_sh, tx_n;
  logic              so_q, so_n, oe_q, oe_n;
  logic              sck_d, cs_d;

  logic              sck_rise, sck_fall, cs_fall, byte_done, id_ok, bank0;
  logic [BYTE_W-1:0] rx_byte;
  logic [IDX_W-1:0]  new_idx;

  assign sck_rise  = sck_s & ~sck_d;
  assign sck_fall  = ~sck_s & sck_d;
  assign cs_fall   = cs_d & ~cs_n_s;
  assign rx_byte   = {rx_sh, si_s};
  assign byte_done = sck_rise && (cnt == CNT_W'(BYTE_W-1));
  assign new_idx   = {rx_byte[RSEL_W-1:0], rx_byte[RSEL_W+1:RSEL_W]};
  assign bank0     = (rx_byte[RSEL_W-1:0] == '0);
  assign id_ok     = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:2] == 2'b00)
                   && (rx_byte[1:0] == addr_pins);
  assign dr_idx    = (state == ST_INSTR) ? new_idx : idx_q;

  always_comb begin
    state_n  = state;
    cnt_n    = cnt;
    rx_sh_n  = rx_sh;
    op_n     = op_q;
    idx_n    = idx_q;
    rd_n     = rd_q;
    tx_n     = tx_sh;
    so_n     = so_q;
    oe_n     = oe_q;
    we_dr    = 1'b0;
    we_wiper = 1'b0;
    wr_data  = rx_byte;
    if (cs_n_s) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      oe_n    = 1'b0;
      rd_n    = 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cs_fall) begin
          state_n = ST_ID;
          cnt_n   = '0;
        end
        ST_ID, ST_INSTR, ST_DATA: if (sck_rise) begin
          cnt_n   = cnt + 1'b1;
          rx_sh_n = {rx_sh[BYTE_W-3:0], si_s};
        end
        default: ;
      endcase
      if (byte_done) begin
        case (state)
          ST_ID: state_n = id_ok ? ST_INSTR : ST_SKIP;
          ST_INSTR: begin
            op_n    = rx_byte[7:4];
            idx_n   = new_idx;
            state_n = ST_SKIP;
            case (rx_byte[7:4])
              OP_RD_WIPER: begin state_n = ST_DATA; rd_n = 1'b1; tx_n = wiper; end
              OP_RD_DR:    begin state_n = ST_DATA; rd_n = 1'b1; tx_n = dr_rdata; end
              OP_WR_WIPER,
              OP_WR_DR:    begin state_n = ST_DATA; rd_n = 1'b0; end
              OP_DR2W:     if (bank0) begin we_wiper = 1'b1; wr_data = dr_rdata; end
              OP_W2DR:     if (bank0) begin we_dr = 1'b1; wr_data = wiper; end
              default: ;
            endcase
          end
          ST_DATA: begin
            state_n = ST_SKIP;
            oe_n    = 1'b0;
            rd_n    = 1'b0;
            if (!rd_q) begin
              we_wiper = (op_q == OP_WR_WIPER);
              we_dr    = (op_q == OP_WR_DR);
            end
          end
          default: ;
        endcase
      end
      if (sck_fall && (state == ST_DATA) && rd_q) begin
        so_n = tx_sh[BYTE_W-1];
        tx_n = {tx_sh[BYTE_W-2:0], 1'b0};
        oe_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      rx_sh <= '0;
      op_q  <= '0;
      idx_q <= '0;
      rd_q  <= 1'b0;
      tx_sh <= '0;
      so_q  <= 1'b0;
      oe_q  <= 1'b0;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      rx_sh <= rx_sh_n;
      op_q  <= op_n;
      idx_q <= idx_n;
      rd_q  <= rd_n;
      tx_sh <= tx_n;
      so_q  <= so_n;
      oe_q  <= oe_n;
      sck_d <= sck_s;
      cs_d  <= cs_n_s;
    end
  end

  assign so    = so_q;
  assign so_oe = oe_q;
  assign ready = (state == ST_IDLE);

  // R12
  oe_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (state == ST_DATA));
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_s) |=> (state == ST_IDLE));
  // R8
  xfer_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_wiper && (state == ST_INSTR)) |-> (dr_idx[IDX_W-1:RSEL_W] == '0));
  // R5
  write_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_wiper || we_dr) |-> sck_rise);
endmodule

// File: rtl/spi_pot_cmd.sv
module spi_pot_cmd
  import spi_pot_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE    = 4'b0101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              si,
  input  logic              cs_n,
  input  logic [1:0]        addr_pins,
  output logic              so,
  output logic              so_oe,
  output logic [BYTE_W-1:0] wiper,
  output logic              ready
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              sck_s, cs_n_s, si_s;
  logic [IDX_W-1:0]  dr_idx;
  logic              we_dr, we_wiper;
  logic [BYTE_W-1:0] wr_data, dr_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  spi_pot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_sync_n), .d(sck), .q(sck_s));
  spi_pot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_sync_n), .d(cs_n), .q(cs_n_s));
  spi_pot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_si (
    .clk(clk), .rst_n(rst_sync_n), .d(si), .q(si_s));

  spi_pot_ctrl #(.DEV_TYPE(DEV_TYPE)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .sck_s(sck_s), .cs_n_s(cs_n_s),
    .si_s(si_s), .addr_pins(addr_pins), .dr_rdata(dr_rdata), .wiper(wiper),
    .dr_idx(dr_idx), .we_dr(we_dr), .we_wiper(we_wiper), .wr_data(wr_data),
    .so(so), .so_oe(so_oe), .ready(ready));

  spi_pot_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we_dr(we_dr), .we_wiper(we_wiper),
    .dr_idx(dr_idx), .wr_data(wr_data), .dr_rdata(dr_rdata), .wiper(wiper));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ready |-> !so_oe);
  // R2
  wiper_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(wiper) |-> !$past(ready));
endmodule

// File: tb/tb_spi_pot_cmd.sv
module tb_spi_pot_cmd;
  localparam int HALF = 8;
  localparam logic [1:0] ADDR = 2'b10;
  localparam logic [7:0] ID_OK = {4'b0101, 2'b00, ADDR};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_n = 1'b1;
  logic [1:0] addr_pins = ADDR;
  logic so, so_oe, ready;
  logic [7:0] wiper;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] val;
    logic       oe;
    logic       cmp_val;
    logic       held;
  } item_t;

  item_t exp_q[$];
  item_t got_q[$];

  always #4 clk = ~clk;

  spi_pot_cmd dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n),
    .addr_pins(addr_pins), .so(so), .so_oe(so_oe), .wiper(wiper), .ready(ready));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits,
                          output logic [7:0] rx, output logic oe_any, output logic held);
    rx = '0; oe_any = 1'b0; held = 1'b1;
    for (int i = 7; i > 7 - nbits; i--) begin
      si = tx[i];
      wait_clk(HALF);
      rx[i] = so;
      oe_any |= so_oe;
      sck = 1'b1;
      wait_clk(HALF);
      if (so !== rx[i]) held = 1'b0;
      sck = 1'b0;
    end
  endtask

  task automatic frame_open();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic frame_close();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic cmd_write(input logic [7:0] id, input logic [7:0] ins, input logic [7:0] data);
    logic [7:0] rx; logic oe; logic h;
    frame_open();
    spi_bits(id, 8, rx, oe, h);
    spi_bits(ins, 8, rx, oe, h);
    spi_bits(data, 8, rx, oe, h);
    frame_close();
  endtask

  task automatic cmd_read(input string tag, input logic [7:0] id, input logic [7:0] ins,
                          input logic [7:0] exp, input logic exp_oe);
    item_t e, g;
    logic [7:0] rx; logic oe; logic h;
    e.tag = tag; e.val = exp; e.oe = exp_oe; e.cmp_val = exp_oe; e.held = 1'b1;
    exp_q.push_back(e);
    frame_open();
    spi_bits(id, 8, rx, oe, h);
    spi_bits(ins, 8, rx, oe, h);
    spi_bits(8'h00, 8, rx, oe, h);
    frame_close();
    g.tag = tag; g.val = rx; g.oe = oe; g.cmp_val = 1'b0; g.held = h;
    got_q.push_back(g);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      item_t e, g;
      wait (got_q.size() != 0);
      g = got_q.pop_front();
      e = exp_q.pop_front();
      chk({e.tag, " oe"}, 32'(g.oe), 32'(e.oe));
      if (e.cmp_val) begin
        chk({e.tag, " data"}, 32'(g.val), 32'(e.val));
        chk({e.tag, " hold (R4)"}, 32'(g.held), 32'(1'b1));
      end
    end
  end

  function automatic logic [7:0] ins(input logic [3:0] op, input logic [1:0] rsel,
                                     input logic [1:0] bank);
    return {op, rsel, bank};
  endfunction

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 reset state
    chk("R1 wiper", 32'(wiper), 32'h0);
    chk("R1 so_oe", 32'(so_oe), 32'h0);
    chk("R1 ready", 32'(ready), 32'h1);
    cmd_read("R1 dr15", ID_OK, ins(4'b1011, 2'd3, 2'd3), 8'h00, 1'b1);

    // R5 / R4 wiper write and read
    cmd_write(ID_OK, ins(4'b1010, 2'd0, 2'd0), 8'hA5);
    chk("R5 wiper", 32'(wiper), 32'hA5);
    cmd_read("R4 rd wiper", ID_OK, ins(4'b1001, 2'd0, 2'd0), 8'hA5, 1'b1);

    // R7 / R6 / R3 data registers in several banks
    cmd_write(ID_OK, ins(4'b1100, 2'd1, 2'd2), 8'h3C);
    cmd_write(ID_OK, ins(4'b1100, 2'd3, 2'd0), 8'h5A);
    cmd_write(ID_OK, ins(4'b1100, 2'd2, 2'd1), 8'h77);
    cmd_read("R6 R3 bank2 reg1", ID_OK, ins(4'b1011, 2'd1, 2'd2), 8'h3C, 1'b1);
    cmd_read("R7 bank0 reg3", ID_OK, ins(4'b1011, 2'd3, 2'd0), 8'h5A, 1'b1);
    cmd_read("R3 bank1 reg2", ID_OK, ins(4'b1011, 2'd2, 2'd1), 8'h77, 1'b1);
    cmd_read("R3 bank1 reg1 untouched", ID_OK, ins(4'b1011, 2'd1, 2'd1), 8'h00, 1'b1);

    // R2 identification mismatches
    cmd_write({4'b0101, 2'b00, 2'b01}, ins(4'b1010, 2'd0, 2'd0), 8'h11);
    chk("R2 wrong addr", 32'(wiper), 32'hA5);
    cmd_write({4'b0110, 2'b00, ADDR}, ins(4'b1010, 2'd0, 2'd0), 8'h22);
    chk("R2 wrong type", 32'(wiper), 32'hA5);
    cmd_write({4'b0101, 2'b01, ADDR}, ins(4'b1010, 2'd0, 2'd0), 8'h33);
    chk("R2 bits3:2 set", 32'(wiper), 32'hA5);
    cmd_read("R2 read bad id", {4'b0101, 2'b00, 2'b11}, ins(4'b1001, 2'd0, 2'd0), 8'h00, 1'b0);

    // R8 data register to wiper
    cmd_write(ID_OK, ins(4'b1101, 2'd3, 2'd0), 8'h00);
    chk("R8 bank0 copy", 32'(wiper), 32'h5A);
    cmd_write(ID_OK, ins(4'b1101, 2'd1, 2'd2), 8'h00);
    chk("R8 bank2 ignored", 32'(wiper), 32'h5A);

    // R9 wiper to data register
    cmd_write(ID_OK, ins(4'b1110, 2'd0, 2'd3), 8'h00);
    cmd_read("R9 bank3 ignored", ID_OK, ins(4'b1011, 2'd0, 2'd3), 8'h00, 1'b1);
    cmd_write(ID_OK, ins(4'b1110, 2'd0, 2'd0), 8'h00);
    cmd_read("R9 bank0 copy", ID_OK, ins(4'b1011, 2'd0, 2'd0), 8'h5A, 1'b1);

    // R10 unknown opcodes
    cmd_write(ID_OK, ins(4'b0000, 2'd0, 2'd0), 8'hFF);
    cmd_write(ID_OK, ins(4'b1111, 2'd1, 2'd0), 8'hEE);
    chk("R10 wiper", 32'(wiper), 32'h5A);
    cmd_read("R10 reg1", ID_OK, ins(4'b1011, 2'd1, 2'd0), 8'h00, 1'b1);

    // R11 / R12 aborted frame
    begin
      logic [7:0] rx; logic oe; logic h;
      frame_open();
      spi_bits(ID_OK, 8, rx, oe, h);
      chk("R12 busy in frame", 32'(ready), 32'h0);
      spi_bits(ins(4'b1010, 2'd0, 2'd0), 8, rx, oe, h);
      spi_bits(8'hC3, 8, rx, oe, h);
      chk("R12 no oe on write", 32'(oe), 32'h0);
      frame_close();
      frame_open();
      spi_bits(ID_OK, 8, rx, oe, h);
      spi_bits(ins(4'b1010, 2'd0, 2'd0), 8, rx, oe, h);
      spi_bits(8'h99, 5, rx, oe, h);
      frame_close();
      chk("R11 ready after abort", 32'(ready), 32'h1);
      chk("R11 wiper kept", 32'(wiper), 32'hC3);
    end
    cmd_read("R11 fresh frame", ID_OK, ins(4'b1001, 2'd0, 2'd0), 8'hC3, 1'b1);
    chk("R12 oe idle", 32'(so_oe), 32'h0);

    wait (got_q.size() == 0);
    wait_clk(4);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_clk(190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule